// File: doc/BRIEF.md
# Periodic Interrupt Generator with Toggle-Supervised Blanking

This block gives an 8-bit processor system its periodic interrupt tick. A free-running binary counter divides the input clock. A short low pulse of fixed width appears on the active-low interrupt line once per period. With a 1 MHz clock, the defaults give a pulse of about 37 us that repeats at roughly 960 Hz.

The block also keeps an eye on the display peripheral. One of its output lines must keep changing state. The line is resynchronised, and each edge in either direction restarts a timeout counter. While that counter has not run out, the blanking output is high and the coil, lamp and display drivers are enabled. When the line stops moving for longer than the programmed limit, blanking drops low and stays low until the line moves again. Blanking is also low after reset, so the drivers stay dark until software proves it is running.

Top module: `irq_blank_wdog`

## Requirements
- R1: While `rst` is high, `irq_n` is high.
- R2: At the first rising clock edge after `rst` is released, `irq_n` goes low.
- R3: Each low pulse of `irq_n` lasts exactly IRQ_LOW clock cycles.
- R4: Falling edges of `irq_n` are exactly IRQ_PERIOD clock cycles apart, and `irq_n` is high for the rest of each period.
- R5: `blank_n` is low during reset and stays low after reset until `wd_line` changes state.
- R6: A change of `wd_line` in either direction drives `blank_n` high. Take edge k as the first rising edge at which the new level is present. With the default two synchroniser stages, `blank_n` is high after edge k+2. The synchroniser flops reset low, so a line that is high at reset release counts as a change.
- R7: If `wd_line` does not change again, `blank_n` stays high for exactly L+1 cycles, where L is the value on `wd_limit`. It then falls, which is after edge k+L+3.
- R8: A further change of `wd_line` while `blank_n` is high restarts the window, so the L+1-cycle count starts again from the new change.
- R9: Once `blank_n` is low, it stays low for any length of time without a change on `wd_line`. The next change raises it again as in R6.
- R10: The elapsed count is compared with `wd_limit` as greater-or-equal. If `wd_limit` is lowered to or below the count already elapsed, `blank_n` falls at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the divider input |
| rst | input | 1 | Synchronous reset, active high |
| wd_line | input | 1 | Supervised peripheral output line, asynchronous |
| wd_limit | input | TMO_W | Timeout limit L in clock cycles |
| irq_n | output | 1 | Periodic interrupt request, active low, registered |
| blank_n | output | 1 | Driver enable, low means blanked, registered |

## Verification
The bench builds the block with IRQ_PERIOD = 40, IRQ_LOW = 6 and an 8-bit limit. With these values, three whole interrupt periods can be compared cycle by cycle against the expected pulse pattern. Small limits (0, 5 and 12) put both the rising and the falling edge of the blanking window inside a few dozen cycles. These limits reach the one-cycle window at L = 0, a retrigger in the middle of a window, a long latched-low stretch, and a limit lowered below the count already elapsed.

// File: rtl/irq_wd_pkg.sv
package irq_wd_pkg;
  // Number of bits needed to hold values 0..max_val.
  function automatic int unsigned width_for(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/irq_divider.sv
module irq_divider
  import irq_wd_pkg::*;
#(
  parameter int unsigned IRQ_PERIOD = 1042,
  parameter int unsigned IRQ_LOW    = 37
) (
  input  logic clk,
  input  logic rst,
  output logic irq_n
);
  localparam int unsigned CW = width_for(IRQ_PERIOD - 1);
  localparam logic [CW-1:0] LAST = CW'(IRQ_PERIOD - 1);
  localparam logic [CW-1:0] LOWN = CW'(IRQ_LOW);

  logic [CW-1:0] phase_q;
  logic          irq_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      irq_n_q <= 1'b1;
    end else begin
      irq_n_q <= !(phase_q < LOWN);
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  end

  assign irq_n = irq_n_q;
endmodule

// File: rtl/line_sync.sv
module line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic edge_o
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sh_q[i] <= 1'b0;
        else     sh_q[i] <= line_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sh_q[i] <= 1'b0;
        else     sh_q[i] <= sh_q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sh_q[STAGES-1];
  end

  assign edge_o = sh_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/toggle_watchdog.sv
module toggle_watchdog #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kick,
  input  logic [TMO_W-1:0] limit,
  output logic             blank_n
);
  logic [TMO_W-1:0] elapsed_q;
  logic             blank_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed_q <= '0;
      blank_n_q <= 1'b0;
    end else if (kick) begin
      elapsed_q <= '0;
      blank_n_q <= 1'b1;
    end else if (elapsed_q >= limit) begin
      blank_n_q <= 1'b0;
    end else begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end

  assign blank_n = blank_n_q;
endmodule

// File: rtl/irq_blank_wdog.sv
module irq_blank_wdog #(
  parameter int unsigned IRQ_PERIOD  = 1042,
  parameter int unsigned IRQ_LOW     = 37,
  parameter int unsigned TMO_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wd_line,
  input  logic [TMO_W-1:0] wd_limit,
  output logic             irq_n,
  output logic             blank_n
);
  logic kick_w;

  irq_divider #(.IRQ_PERIOD(IRQ_PERIOD), .IRQ_LOW(IRQ_LOW)) u_div (
    .clk(clk), .rst(rst), .irq_n(irq_n)
  );

  line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_in(wd_line), .edge_o(kick_w)
  );

  toggle_watchdog #(.TMO_W(TMO_W)) u_wd (
    .clk(clk), .rst(rst), .kick(kick_w), .limit(wd_limit), .blank_n(blank_n)
  );
endmodule

// File: rtl/irq_wd_chk.sv
module irq_wd_chk
  import irq_wd_pkg::*;
#(
  parameter int unsigned IRQ_PERIOD = 1042,
  parameter int unsigned IRQ_LOW    = 37
) (
  input logic clk,
  input logic rst,
  input logic irq_n,
  input logic blank_n,
  input logic kick
);
  localparam int unsigned LW = width_for(IRQ_LOW + 1);
  localparam int unsigned GW = width_for(IRQ_PERIOD + 1);

  logic [LW-1:0] low_run;
  logic [GW-1:0] gap;
  logic          prev_irq, seen_fall, fall;

  assign fall = prev_irq && !irq_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run   <= '0;
      gap       <= '0;
      prev_irq  <= 1'b1;
      seen_fall <= 1'b0;
    end else begin
      prev_irq <= irq_n;
      if (irq_n) low_run <= '0;
      else if (low_run != {LW{1'b1}}) low_run <= low_run + 1'b1;
      if (fall) begin
        gap       <= GW'(1);
        seen_fall <= 1'b1;
      end else if (gap != {GW{1'b1}}) begin
        gap <= gap + 1'b1;
      end
    end
  end

  // R1
  irq_reset_high_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> irq_n);

  // R3
  irq_low_width_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> (low_run < LW'(IRQ_LOW)));

  // R4
  irq_period_chk: assert property (@(posedge clk) disable iff (rst)
    (fall && seen_fall) |-> (gap == GW'(IRQ_PERIOD)));

  // R5
  blank_reset_low_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !blank_n);

  // R6
  blank_follow_kick_chk: assert property (@(posedge clk) disable iff (rst)
    kick |=> blank_n);

  // R8
  blank_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(blank_n) |-> $past(kick));

  // R9
  blank_latched_chk: assert property (@(posedge clk) disable iff (rst)
    (!blank_n && !kick) |=> !blank_n);
endmodule

bind irq_blank_wdog irq_wd_chk #(.IRQ_PERIOD(IRQ_PERIOD), .IRQ_LOW(IRQ_LOW)) chk_i (
  .clk(clk), .rst(rst), .irq_n(irq_n), .blank_n(blank_n), .kick(kick_w)
);

// File: tb/irq_blank_wdog_tb_top.sv
module irq_blank_wdog_tb_top;
  localparam int unsigned P  = 40;
  localparam int unsigned W  = 6;
  localparam int unsigned TW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wd_line = 1'b0;
  logic [TW-1:0] wd_limit = 8'd5;
  logic          irq_n, blank_n;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  irq_blank_wdog #(.IRQ_PERIOD(P), .IRQ_LOW(W), .TMO_W(TW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .wd_line(wd_line), .wd_limit(wd_limit),
    .irq_n(irq_n), .blank_n(blank_n)
  );

  // {limit, edges after toggle before sampling, expected blank_n}
  localparam logic [16:0] WD_VEC [8] = '{
    {8'd5,  8'd2,  1'b0},
    {8'd5,  8'd3,  1'b1},
    {8'd5,  8'd8,  1'b1},
    {8'd5,  8'd9,  1'b0},
    {8'd0,  8'd3,  1'b1},
    {8'd0,  8'd4,  1'b0},
    {8'd12, 8'd15, 1'b1},
    {8'd12, 8'd16, 1'b0}
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wait_blank_low();
    @(negedge clk);
    while (blank_n) @(negedge clk);
  endtask

  task automatic edges_then_sample(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("[TB] watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // Reset state
    repeat (3) @(negedge clk);
    chk(irq_n, 1'b1, "R1");
    chk(blank_n, 1'b0, "R5");
    rst = 1'b0;

    // Interrupt pattern over three periods
    for (int c = 1; c <= 3 * P; c++) begin
      edges_then_sample(1);
      if (c == 1) chk(irq_n, 1'b0, "R2");
      else if (((c - 1) % P) < W) chk(irq_n, 1'b0, "R3");
      else chk(irq_n, 1'b1, "R4");
    end
    chk(blank_n, 1'b0, "R5");

    // Table walk: window edges for several limits, toggles alternate direction
    for (int i = 0; i < 8; i++) begin
      wait_blank_low();
      wd_limit = WD_VEC[i][16:9];
      wd_line  = ~wd_line;
      edges_then_sample(int'(WD_VEC[i][8:1]));
      chk(blank_n, WD_VEC[i][0], WD_VEC[i][0] ? "R6" : (WD_VEC[i][8:1] < 8'd3 ? "R6" : "R7"));
    end

    // R8: retrigger in the middle of a window
    wait_blank_low();
    wd_limit = 8'd5;
    wd_line  = ~wd_line;
    edges_then_sample(6);
    chk(blank_n, 1'b1, "R8");
    wd_line = ~wd_line;
    edges_then_sample(7);
    chk(blank_n, 1'b1, "R8");
    edges_then_sample(2);
    chk(blank_n, 1'b0, "R8");

    // R9: stays latched low for a long quiet stretch, then re-enables
    for (int k = 0; k < 3; k++) begin
      edges_then_sample(100);
      chk(blank_n, 1'b0, "R9");
    end
    wd_line = ~wd_line;
    edges_then_sample(3);
    chk(blank_n, 1'b1, "R9");

    // R10: limit lowered below the elapsed count
    wait_blank_low();
    wd_limit = 8'd50;
    wd_line  = ~wd_line;
    edges_then_sample(13);
    chk(blank_n, 1'b1, "R10");
    wd_limit = 8'd3;
    edges_then_sample(1);
    chk(blank_n, 1'b0, "R10");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule